// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block is the power-state sequencer of a small 8-bit microcontroller. It takes the decoded STOP and WAIT instruction strobes from the CPU and decides which clocks keep running. A WAIT strobe gates only the CPU clock. A STOP strobe has two possible results. In full stop the oscillator and every internal clock shut down. In halt the oscillator and the watchdog stay alive, much as in wait. A mode-option bit, captured while reset is held, picks between full stop and halt.

Full stop can end only through the external IRQ line or through reset. After either one, the block turns the oscillator back on and holds the CPU clock off while an internal down-counter runs through a fixed stabilization count. Only then does it raise ready. Halt ends on any enabled interrupt request, after a short delay that can be set. A STOP strobe sends a one-cycle pulse that clears the CPU's interrupt mask, so that IRQ is able to wake the part. The block only gates clocks. It never resets registers or I/O state.

Top module: `lpm_ctrl`

## Requirements
- R1: With the captured option at 0, a STOP strobe accepted in run mode gives, from the next cycle on, `osc_en_o`, `cpu_clk_en_o`, `per_clk_en_o`, `wdg_clk_en_o` and `ready_o` all low.
- R2: With the captured option at 1, a STOP strobe accepted in run mode gives, from the next cycle on, a CPU clock that is gated and a ready that is low. The oscillator, the peripheral clock and the watchdog clock stay enabled.
- R3: `clr_imask_o` is high for exactly one cycle: the cycle that follows an accepted STOP strobe, under either option value. A WAIT strobe never raises it.
- R4: Full stop is left only through `irq_i` (or reset). `int_req_i` and the instruction strobes leave every enable low.
- R5: When `irq_i` is seen in full stop, the next cycle has the oscillator enabled and the CPU, peripheral and watchdog clocks off. This lasts for exactly STAB_CYCLES (default 4064) cycles, after which `ready_o` and all enables are high.
- R6: A WAIT strobe gates only the CPU clock, with oscillator, peripheral and watchdog still enabled. `int_req_i` or `irq_i` brings the block back to run, with ready high, on the next cycle and with no delay.
- R7: In halt, `int_req_i` or `irq_i` starts a delay of HALT_CYCLES (default 16) cycles. During it the CPU clock stays gated while the oscillator, peripheral and watchdog clocks keep running. After it, `ready_o` rises.
- R8: While `rst_ni` is low, the oscillator is on and the other enables and ready are off. After reset is released, `ready_o` rises after exactly STAB_CYCLES cycles.
- R9: A STOP or WAIT strobe that arrives in the same cycle as `irq_i` or `int_req_i` is dropped. The block stays in run and sends no `clr_imask_o` pulse.
- R10: `halt_opt_i` is captured only while reset is asserted. Any change to it after reset has no effect on how STOP behaves.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Internal clock |
| rst_ni | input | 1 | External reset, active low, asynchronous |
| stop_i | input | 1 | Decoded STOP instruction strobe |
| wait_i | input | 1 | Decoded WAIT instruction strobe |
| halt_opt_i | input | 1 | Mode option: 1 turns STOP into halt, captured during reset |
| irq_i | input | 1 | External IRQ request |
| int_req_i | input | 1 | Any enabled interrupt request |
| osc_en_o | output | 1 | Oscillator enable |
| cpu_clk_en_o | output | 1 | CPU clock gate enable |
| per_clk_en_o | output | 1 | Peripheral and timer clock gate enable |
| wdg_clk_en_o | output | 1 | Watchdog clock enable |
| clr_imask_o | output | 1 | One-cycle pulse that clears the interrupt mask |
| ready_o | output | 1 | CPU may run |

## Verification
Mode entry and the `clr_imask_o` pulse become visible one clock after the strobe, because the state register and the pulse register are the only flops in that path. Wake from wait also shows up one clock after the request. Ready after a full stop or a reset arrives STAB_CYCLES clocks after the cycle that enters stabilization, and ready after halt arrives HALT_CYCLES clocks after it. The bench drives and samples on the falling edge. It takes each one-cycle result at the very next falling edge. For the two delays, it counts the falling edges until ready rises and compares that count with the expected value, so an error of one cycle in either direction is caught.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [2:0] {
    ST_RUN  = 3'd0,
    ST_WAIT = 3'd1,
    ST_HALT = 3'd2,
    ST_STOP = 3'd3,
    ST_STAB = 3'd4
  } lpm_state_e;
endpackage

// File: rtl/lpm_opt_sample.sv
module lpm_opt_sample (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic opt_i,
  output logic opt_o
);
  logic opt_q;

  // follows the pin only while reset is held, frozen afterwards
  always_ff @(posedge clk_i) begin
    if (!rst_ni) opt_q <= opt_i;
  end

  assign opt_o = opt_q;
endmodule

// File: rtl/lpm_stab_cnt.sv
module lpm_stab_cnt #(
  parameter int STAB_CYCLES = 4064,
  parameter int HALT_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_stop_i,
  input  logic load_halt_i,
  input  logic run_i,
  output logic last_o
);
  localparam int CNT_W = $clog2(STAB_CYCLES + 1);
  localparam logic [CNT_W-1:0] STAB_LD = CNT_W'(STAB_CYCLES);
  localparam logic [CNT_W-1:0] HALT_LD = CNT_W'(HALT_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= STAB_LD;
    else if (load_stop_i)              cnt_q <= STAB_LD;
    else if (load_halt_i)              cnt_q <= HALT_LD;
    else if (run_i && cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import lpm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       stop_i,
  input  logic       wait_i,
  input  logic       irq_i,
  input  logic       int_req_i,
  input  logic       opt_i,
  input  logic       cnt_last_i,
  output lpm_state_e state_o,
  output logic       from_halt_o,
  output logic       load_stop_o,
  output logic       load_halt_o,
  output logic       clr_imask_o
);
  lpm_state_e state_q, state_d;
  logic       from_halt_q, clr_q;
  logic       wake_any;

  assign wake_any    = irq_i | int_req_i;
  assign load_stop_o = (state_q == ST_STOP) & irq_i;
  assign load_halt_o = (state_q == ST_HALT) & wake_any;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN: begin
        if (!wake_any) begin
          if (stop_i)      state_d = opt_i ? ST_HALT : ST_STOP;
          else if (wait_i) state_d = ST_WAIT;
        end
      end
      ST_WAIT: if (wake_any)   state_d = ST_RUN;
      ST_HALT: if (wake_any)   state_d = ST_STAB;
      ST_STOP: if (irq_i)      state_d = ST_STAB;
      ST_STAB: if (cnt_last_i) state_d = ST_RUN;
      default:                 state_d = ST_STAB;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_STAB;
      from_halt_q <= 1'b0;
      clr_q       <= 1'b0;
    end else begin
      state_q <= state_d;
      clr_q   <= (state_q == ST_RUN) & ~wake_any & stop_i;
      if (load_halt_o)      from_halt_q <= 1'b1;
      else if (load_stop_o) from_halt_q <= 1'b0;
    end
  end

  assign state_o     = state_q;
  assign from_halt_o = from_halt_q;
  assign clr_imask_o = clr_q;
endmodule

// File: rtl/lpm_gate_dec.sv
module lpm_gate_dec
  import lpm_pkg::*;
(
  input  lpm_state_e state_i,
  input  logic       from_halt_i,
  output logic       osc_en_o,
  output logic       cpu_clk_en_o,
  output logic       per_clk_en_o,
  output logic       wdg_clk_en_o,
  output logic       ready_o
);
  logic low_run;

  // wait, halt and the halt-exit delay keep the slow domains alive
  assign low_run = (state_i == ST_WAIT) | (state_i == ST_HALT) |
                   ((state_i == ST_STAB) & from_halt_i);

  assign osc_en_o     = (state_i != ST_STOP);
  assign cpu_clk_en_o = (state_i == ST_RUN);
  assign ready_o      = (state_i == ST_RUN);
  assign per_clk_en_o = (state_i == ST_RUN) | low_run;
  assign wdg_clk_en_o = (state_i == ST_RUN) | low_run;
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int STAB_CYCLES = 4064,
  parameter int HALT_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stop_i,
  input  logic wait_i,
  input  logic halt_opt_i,
  input  logic irq_i,
  input  logic int_req_i,
  output logic osc_en_o,
  output logic cpu_clk_en_o,
  output logic per_clk_en_o,
  output logic wdg_clk_en_o,
  output logic clr_imask_o,
  output logic ready_o
);
  lpm_state_e state;
  logic       opt_q, from_halt, load_stop, load_halt, cnt_last, stab_run;

  assign stab_run = (state == ST_STAB);

  lpm_opt_sample u_opt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .opt_i (halt_opt_i),
    .opt_o (opt_q)
  );

  lpm_stab_cnt #(
    .STAB_CYCLES(STAB_CYCLES),
    .HALT_CYCLES(HALT_CYCLES)
  ) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_stop_i(load_stop),
    .load_halt_i(load_halt),
    .run_i      (stab_run),
    .last_o     (cnt_last)
  );

  lpm_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stop_i     (stop_i),
    .wait_i     (wait_i),
    .irq_i      (irq_i),
    .int_req_i  (int_req_i),
    .opt_i      (opt_q),
    .cnt_last_i (cnt_last),
    .state_o    (state),
    .from_halt_o(from_halt),
    .load_stop_o(load_stop),
    .load_halt_o(load_halt),
    .clr_imask_o(clr_imask_o)
  );

  lpm_gate_dec u_dec (
    .state_i     (state),
    .from_halt_i (from_halt),
    .osc_en_o    (osc_en_o),
    .cpu_clk_en_o(cpu_clk_en_o),
    .per_clk_en_o(per_clk_en_o),
    .wdg_clk_en_o(wdg_clk_en_o),
    .ready_o     (ready_o)
  );
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic stop_i,
  input logic wait_i,
  input logic irq_i,
  input logic int_req_i,
  input logic opt_i,
  input logic osc_en_o,
  input logic cpu_clk_en_o,
  input logic per_clk_en_o,
  input logic wdg_clk_en_o,
  input logic clr_imask_o,
  input logic ready_o
);
  assert_stop_entry_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && stop_i && !irq_i && !int_req_i && !opt_i |=>
      !osc_en_o && !cpu_clk_en_o && !per_clk_en_o && !wdg_clk_en_o && !ready_o);

  assert_halt_entry_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && stop_i && !irq_i && !int_req_i && opt_i |=>
      osc_en_o && per_clk_en_o && wdg_clk_en_o && !cpu_clk_en_o && !ready_o);

  assert_imask_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && stop_i && !irq_i && !int_req_i |=> clr_imask_o);

  assert_imask_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_imask_o |=> !clr_imask_o);

  assert_stop_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_en_o && !irq_i |=> !osc_en_o);

  assert_stop_exit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_en_o && irq_i |=> osc_en_o && !cpu_clk_en_o && !per_clk_en_o && !ready_o);

  assert_wait_entry_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && wait_i && !stop_i && !irq_i && !int_req_i |=>
      !cpu_clk_en_o && osc_en_o && per_clk_en_o && wdg_clk_en_o && !clr_imask_o);

  assert_wake_priority_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && (irq_i || int_req_i) |=> ready_o && !clr_imask_o);
endmodule

bind lpm_ctrl lpm_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .stop_i      (stop_i),
  .wait_i      (wait_i),
  .irq_i       (irq_i),
  .int_req_i   (int_req_i),
  .opt_i       (opt_q),
  .osc_en_o    (osc_en_o),
  .cpu_clk_en_o(cpu_clk_en_o),
  .per_clk_en_o(per_clk_en_o),
  .wdg_clk_en_o(wdg_clk_en_o),
  .clr_imask_o (clr_imask_o),
  .ready_o     (ready_o)
);

// File: tb/sim_lpm_ctrl.sv
module sim_lpm_ctrl;
  localparam int STAB = 4064;
  localparam int HALT = 16;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic stop_i = 1'b0, wait_i = 1'b0, halt_opt_i = 1'b0;
  logic irq_i = 1'b0, int_req_i = 1'b0;
  logic osc_en_o, cpu_clk_en_o, per_clk_en_o, wdg_clk_en_o, clr_imask_o, ready_o;
  int   n_tests = 0;
  int   n_fail  = 0;

  always #2 clk_i = ~clk_i;

  lpm_ctrl #(.STAB_CYCLES(STAB), .HALT_CYCLES(HALT)) u0 (
    .clk_i, .rst_ni, .stop_i, .wait_i, .halt_opt_i, .irq_i, .int_req_i,
    .osc_en_o, .cpu_clk_en_o, .per_clk_en_o, .wdg_clk_en_o, .clr_imask_o, .ready_o
  );

  // {osc, cpu, per, wdg, ready}
  function automatic logic [4:0] en_vec();
    return {osc_en_o, cpu_clk_en_o, per_clk_en_o, wdg_clk_en_o, ready_o};
  endfunction

  task automatic cyc();
    @(negedge clk_i);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic count_ready(input string req, input int exp);
    int n = 0;
    while (!ready_o && n < 3 * STAB) begin
      cyc();
      n++;
    end
    chk(req, n, exp);
  endtask

  task automatic t_reset(input logic opt);
    rst_ni = 1'b0;
    halt_opt_i = opt;
    stop_i = 0; wait_i = 0; irq_i = 0; int_req_i = 0;
    repeat (4) cyc();
    chk("R8 in reset", en_vec(), 5'b10000);
    rst_ni = 1'b1;
    count_ready("R8 reset delay", STAB);
    chk("R8 run after reset", en_vec(), 5'b11111);
  endtask

  task automatic t_stop();
    stop_i = 1; cyc(); stop_i = 0;
    chk("R1 stop entry", en_vec(), 5'b00000);
    chk("R3 pulse on stop", clr_imask_o, 1);
    cyc();
    chk("R3 pulse ends", clr_imask_o, 0);
    int_req_i = 1; repeat (3) cyc(); int_req_i = 0;
    chk("R4 int_req ignored", en_vec(), 5'b00000);
    wait_i = 1; stop_i = 1; cyc(); wait_i = 0; stop_i = 0;
    chk("R4 strobes ignored", en_vec(), 5'b00000);
    irq_i = 1; cyc(); irq_i = 0;
    chk("R5 stabilize", en_vec(), 5'b10000);
    count_ready("R5 stop delay", STAB);
    chk("R5 run after stop", en_vec(), 5'b11111);
  endtask

  task automatic t_wait();
    wait_i = 1; cyc(); wait_i = 0;
    chk("R6 wait entry", en_vec(), 5'b10110);
    chk("R3 no pulse on wait", clr_imask_o, 0);
    repeat (3) cyc();
    chk("R6 wait held", en_vec(), 5'b10110);
    int_req_i = 1; cyc(); int_req_i = 0;
    chk("R6 wake int_req", en_vec(), 5'b11111);
    wait_i = 1; cyc(); wait_i = 0;
    irq_i = 1; cyc(); irq_i = 0;
    chk("R6 wake irq", en_vec(), 5'b11111);
  endtask

  task automatic t_prio();
    stop_i = 1; int_req_i = 1; cyc(); stop_i = 0; int_req_i = 0;
    chk("R9 stop vs int_req", en_vec(), 5'b11111);
    chk("R9 no pulse", clr_imask_o, 0);
    wait_i = 1; irq_i = 1; cyc(); wait_i = 0; irq_i = 0;
    chk("R9 wait vs irq", en_vec(), 5'b11111);
  endtask

  task automatic t_halt();
    halt_opt_i = 1'b0;  // option changed after reset, must be ignored
    cyc();
    stop_i = 1; cyc(); stop_i = 0;
    chk("R10 option kept", osc_en_o, 1);
    chk("R2 halt entry", en_vec(), 5'b10110);
    chk("R3 pulse on halt", clr_imask_o, 1);
    repeat (5) cyc();
    chk("R2 halt held", en_vec(), 5'b10110);
    int_req_i = 1; cyc(); int_req_i = 0;
    chk("R7 halt delay state", en_vec(), 5'b10110);
    count_ready("R7 halt delay", HALT);
    chk("R7 run after halt", en_vec(), 5'b11111);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    cyc();
    t_reset(1'b0);
    t_stop();
    t_wait();
    t_prio();
    t_reset(1'b1);
    t_halt();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule